// File: doc/BRIEF.md
# Phase Build-Out Event Controller

This block sits beside a digital phase-locked loop and decides when a sudden step in the measured phase error should be absorbed into a stored offset rather than tracked by the loop. Each sample tick it receives a signed phase-error value. That value is taken between the selected reference and a delayed internal copy of the loop output. The block subtracts its own accumulated offset to get a residual, and watches that residual in two stages. A residual above a small fixed level opens a time window. An absorption event fires only if, inside that window, the residual grows past a larger programmable threshold. A window that runs out without that crossing closes and changes nothing.

An event can also come from a reference-switch strobe, or from turning the feature on while the loop reports lock. On any event the block raises a holdover flag, which holds loop steering. For a fixed power-of-two number of valid samples it averages the residual, then adds that average and a clamped fine bias into the accumulated offset. The offset drives the loop phase detector. The feature has an enable level, a second enable that allows automatic triggering on transients, and a freeze level. Freeze keeps the offset and refuses every new event. Disabling the feature clears the offset, and a separate clamped output-phase adjustment then applies.

Top module: `phase_buildout_ctrl`

## Requirements
- R1: After reset, `ofs_out` is 0 and `holdover` is 0. With `cfg_en` high, `adj_out` is 0 and `bias_out` equals the clamped `fine_bias`.
- R2: With `cfg_en` and `cfg_auto` high and `cfg_freeze` low, a valid sample whose |residual| (`smp_err` minus `ofs_out`) is strictly above SMALL_THR opens a window. A later valid sample, among the next WIN_TICKS valid samples, whose |residual| is strictly above `thr_large` starts an event, so `holdover` is 1 after that clock edge.
- R3: When WIN_TICKS valid samples pass inside an open window with no crossing, the window closes and `ofs_out` is unchanged. The next large sample only opens a new window, and an event needs a further sample.
- R4: An event holds `holdover` at 1 for exactly 2^MEAS_LOG2 valid samples. On the edge of the last one, `holdover` returns to 0 and `ofs_out` gains floor(sum of residuals / 2^MEAS_LOG2) plus `bias_out`, saturated to the `ofs_out` range. `ofs_out` does not change at any other time while `cfg_en` is high.
- R5: With `cfg_auto` low, phase transients never start an event.
- R6: A one-cycle `ref_sw` pulse starts an event when `cfg_en` is high, `cfg_freeze` is low and `holdover` is 0.
- R7: While `cfg_freeze` is high, neither `ref_sw` nor transients start an event, and `ofs_out` keeps its value.
- R8: While `cfg_en` is low, `ofs_out` is 0 from the next edge on, and any measurement in progress is dropped. If `cfg_en` is low in the same cycle as the last measure sample, the clear wins.
- R9: A 0-to-1 change of `cfg_en` while `lock_in` is high starts an event. With `lock_in` low it does not.
- R10: `bias_out` is the two's-complement `fine_bias` clamped to ±BIAS_LIM (14 by default).
- R11: `adj_out` is `adj_phase` clamped to ±ADJ_LIM (33333 by default) while `cfg_en` is low, and 0 while `cfg_en` is high.
- R12: Cycles with `smp_valid` low neither count toward the window or the measure period nor enter the average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A phase-error sample is present this cycle (one tick) |
| smp_err | input | PH_W | Signed phase error, reference versus delayed output copy |
| thr_large | input | PH_W | Unsigned event threshold used inside an open window |
| cfg_en | input | 1 | Feature enable level |
| cfg_auto | input | 1 | Second enable allowing automatic triggering on transients |
| cfg_freeze | input | 1 | Freeze: keep the offset, refuse new events |
| lock_in | input | 1 | Loop locked status |
| ref_sw | input | 1 | One-cycle strobe on a reference switch |
| fine_bias | input | BIAS_W | Signed fine bias added per absorbed event |
| adj_phase | input | ADJ_W | Signed output-phase adjustment used while disabled |
| holdover | output | 1 | Temporary holdover while a residual is measured |
| ofs_out | output | OFS_W | Accumulated offset applied to the phase detector |
| bias_out | output | BIAS_W | Clamped fine bias |
| adj_out | output | ADJ_W | Clamped output-phase adjustment, 0 while enabled |

## Verification
The measure period can end in the same clock in which `cfg_en` drops. In that cycle the offset update and the disable clear both target the offset register. The bench lets a `ref_sw` event collect three samples, then presents the fourth valid sample on the same edge as `cfg_en` low. It judges the outcome by `ofs_out` being 0 and `holdover` being 0 right after that edge, with no stale update after the feature is enabled again. A second contest sets the last in-window sample against window expiry. The crossing sample at the final window position must fire, and one sample later it must only reopen the window.

// File: rtl/phbo_pkg.sv
package phbo_pkg;

   typedef enum logic [0:0] {
      DET_IDLE  = 1'b0,
      DET_WATCH = 1'b1
   } det_st_e;

endpackage

// File: rtl/phbo_sat.sv
module phbo_sat #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   parameter int LIM   = 127
) (
   input  logic signed [IN_W-1:0]  x,
   output logic signed [OUT_W-1:0] y
);

   if (IN_W < OUT_W) begin : g_bad_w
      $error("phbo_sat: IN_W must not be below OUT_W");
   end
   if (LIM < 0 || OUT_W > 31 || LIM >= (1 << (OUT_W - 1))) begin : g_bad_lim
      $error("phbo_sat: LIM must fit the signed output");
   end

   localparam logic signed [IN_W-1:0] HI = IN_W'(LIM);
   localparam logic signed [IN_W-1:0] LO = -HI;

   always_comb begin
      if (x > HI)
         y = HI[OUT_W-1:0];
      else if (x < LO)
         y = LO[OUT_W-1:0];
      else
         y = x[OUT_W-1:0];
   end

endmodule

// File: rtl/phbo_detect.sv
module phbo_detect
   import phbo_pkg::*;
#(
   parameter int RW        = 21,
   parameter int THR_W     = 16,
   parameter int WIN_TICKS = 64,
   parameter int SMALL_THR = 156
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             smp_valid,
   input  logic [RW-1:0]    mag,
   input  logic [THR_W-1:0] thr_large,
   output logic             fire
);

   if (WIN_TICKS < 1) begin : g_bad_win
      $error("phbo_detect: WIN_TICKS must be at least 1");
   end
   if (RW <= THR_W) begin : g_bad_thr
      $error("phbo_detect: residual must be wider than the threshold");
   end

   localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
   localparam logic [CW-1:0] LAST    = CW'(WIN_TICKS - 1);
   localparam logic [RW-1:0] SMALL_V = RW'(SMALL_THR);

   det_st_e       st;
   logic [CW-1:0] cnt;
   logic          over_small;
   logic          over_large;

   assign over_small = mag > SMALL_V;
   assign over_large = mag > {{(RW - THR_W){1'b0}}, thr_large};
   assign fire       = (st == DET_WATCH) & smp_valid & ~hold & over_large;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= DET_IDLE;
         cnt <= '0;
      end else if (hold) begin
         st  <= DET_IDLE;
         cnt <= '0;
      end else if (smp_valid) begin
         unique case (st)
            DET_IDLE: begin
               if (over_small) begin
                  st  <= DET_WATCH;
                  cnt <= '0;
               end
            end
            DET_WATCH: begin
               if (over_large || cnt == LAST) begin
                  st  <= DET_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= DET_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/phbo_measure.sv
module phbo_measure #(
   parameter int RW     = 21,
   parameter int LOG2N  = 2,
   parameter bit ROUND  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 abort,
   input  logic                 smp_valid,
   input  logic signed [RW-1:0] resid,
   output logic                 busy,
   output logic                 done,
   output logic signed [RW-1:0] mean
);

   if (LOG2N < 1 || LOG2N > 8) begin : g_bad_n
      $error("phbo_measure: LOG2N must be 1..8");
   end

   localparam int N  = 1 << LOG2N;
   localparam int SW = RW + LOG2N;
   localparam int CW = LOG2N;
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] total;
   logic signed [SW-1:0] scaled;
   logic [CW-1:0]        cnt;
   logic                 last;

   assign total = sum + {{LOG2N{resid[RW-1]}}, resid};
   assign last  = busy & smp_valid & (cnt == LAST);
   assign done  = last & ~abort;

   if (ROUND) begin : g_round
      localparam logic signed [SW-1:0] HALF = SW'(N / 2);
      assign scaled = (total + HALF) >>> LOG2N;
   end else begin : g_floor
      assign scaled = total >>> LOG2N;
   end

   assign mean = scaled[RW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         sum  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
         sum  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
         sum  <= '0;
      end else if (busy && smp_valid) begin
         if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
            sum  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
            sum <= total;
         end
      end
   end

endmodule

// File: rtl/phase_buildout_ctrl.sv
module phase_buildout_ctrl #(
   parameter int PH_W       = 16,
   parameter int OFS_W      = 20,
   parameter int WIN_TICKS  = 64,
   parameter int SMALL_THR  = 156,
   parameter int MEAS_LOG2  = 2,
   parameter bit MEAN_ROUND = 1'b0,
   parameter int BIAS_W     = 5,
   parameter int BIAS_LIM   = 14,
   parameter int ADJ_W      = 17,
   parameter int ADJ_LIM    = 33333
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic signed [PH_W-1:0]  smp_err,
   input  logic [PH_W-1:0]         thr_large,
   input  logic                    cfg_en,
   input  logic                    cfg_auto,
   input  logic                    cfg_freeze,
   input  logic                    lock_in,
   input  logic                    ref_sw,
   input  logic signed [BIAS_W-1:0] fine_bias,
   input  logic signed [ADJ_W-1:0] adj_phase,
   output logic                    holdover,
   output logic signed [OFS_W-1:0] ofs_out,
   output logic signed [BIAS_W-1:0] bias_out,
   output logic signed [ADJ_W-1:0] adj_out
);

   if (PH_W >= OFS_W || OFS_W > 30) begin : g_bad_ofs
      $error("phase_buildout_ctrl: OFS_W must exceed PH_W and stay below 31");
   end
   if (BIAS_W >= OFS_W) begin : g_bad_bias
      $error("phase_buildout_ctrl: BIAS_W must be narrower than OFS_W");
   end

   localparam int RW      = OFS_W + 1;
   localparam int SUM_W   = OFS_W + 3;
   localparam int OFS_LIM = (1 << (OFS_W - 1)) - 1;

   logic signed [OFS_W-1:0] acc;
   logic signed [RW-1:0]    resid;
   logic [RW-1:0]           mag;
   logic                    en_q;
   logic                    det_hold;
   logic                    det_fire;
   logic                    en_rise_lk;
   logic                    trig_ok;
   logic                    start;
   logic                    busy;
   logic                    done;
   logic signed [RW-1:0]    mean;
   logic signed [BIAS_W-1:0] bias_c;
   logic signed [ADJ_W-1:0] adj_c;
   logic signed [SUM_W-1:0] acc_sum;
   logic signed [OFS_W-1:0] acc_nxt;

   // residual seen by the loop after the stored offset
   assign resid = {{(RW - PH_W){smp_err[PH_W-1]}}, smp_err} - {acc[OFS_W-1], acc};
   assign mag   = resid[RW-1] ? (~resid + 1'b1) : resid;

   assign det_hold   = ~(cfg_en & cfg_auto) | cfg_freeze | busy;
   assign en_rise_lk = cfg_en & ~en_q & lock_in;
   assign trig_ok    = cfg_en & ~cfg_freeze & ~busy;
   assign start      = trig_ok & (det_fire | ref_sw | en_rise_lk);

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b1;
      else
         en_q <= cfg_en;
   end

   phbo_detect #(
      .RW       (RW),
      .THR_W    (PH_W),
      .WIN_TICKS(WIN_TICKS),
      .SMALL_THR(SMALL_THR)
   ) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (det_hold),
      .smp_valid(smp_valid),
      .mag      (mag),
      .thr_large(thr_large),
      .fire     (det_fire)
   );

   phbo_measure #(
      .RW   (RW),
      .LOG2N(MEAS_LOG2),
      .ROUND(MEAN_ROUND)
   ) u_measure (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .abort    (~cfg_en),
      .smp_valid(smp_valid),
      .resid    (resid),
      .busy     (busy),
      .done     (done),
      .mean     (mean)
   );

   phbo_sat #(.IN_W(BIAS_W), .OUT_W(BIAS_W), .LIM(BIAS_LIM)) u_bias_sat (
      .x(fine_bias),
      .y(bias_c)
   );

   phbo_sat #(.IN_W(ADJ_W), .OUT_W(ADJ_W), .LIM(ADJ_LIM)) u_adj_sat (
      .x(adj_phase),
      .y(adj_c)
   );

   assign acc_sum = {{(SUM_W - OFS_W){acc[OFS_W-1]}}, acc}
                  + {{(SUM_W - RW){mean[RW-1]}}, mean}
                  + {{(SUM_W - BIAS_W){bias_c[BIAS_W-1]}}, bias_c};

   phbo_sat #(.IN_W(SUM_W), .OUT_W(OFS_W), .LIM(OFS_LIM)) u_acc_sat (
      .x(acc_sum),
      .y(acc_nxt)
   );

   // disable has priority over a completing measurement
   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (!cfg_en)
         acc <= '0;
      else if (done)
         acc <= acc_nxt;
   end

   assign holdover = busy;
   assign ofs_out  = acc;
   assign bias_out = bias_c;
   assign adj_out  = cfg_en ? '0 : adj_c;

endmodule

// File: rtl/phbo_chk.sv
module phbo_chk #(
   parameter int OFS_W    = 20,
   parameter int BIAS_W   = 5,
   parameter int BIAS_LIM = 14,
   parameter int ADJ_W    = 17,
   parameter int ADJ_LIM  = 33333
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_en,
   input logic                     cfg_freeze,
   input logic                     ref_sw,
   input logic                     holdover,
   input logic signed [OFS_W-1:0]  ofs_out,
   input logic signed [BIAS_W-1:0] bias_out,
   input logic signed [ADJ_W-1:0]  adj_out
);

   // R4
   ofs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !holdover) |=> $stable(ofs_out));

   // R6
   sw_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_sw && cfg_en && !cfg_freeze && !holdover) |=> holdover);

   // R7
   freeze_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_freeze && !holdover) |=> !holdover);

   // R8
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (ofs_out == '0 && !holdover));

   // R10
   bias_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bias_out) <= BIAS_LIM) && (int'(bias_out) >= -BIAS_LIM));

   // R11
   adj_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(adj_out) <= ADJ_LIM) && (int'(adj_out) >= -ADJ_LIM));

endmodule

bind phase_buildout_ctrl phbo_chk #(
   .OFS_W   (OFS_W),
   .BIAS_W  (BIAS_W),
   .BIAS_LIM(BIAS_LIM),
   .ADJ_W   (ADJ_W),
   .ADJ_LIM (ADJ_LIM)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .cfg_freeze(cfg_freeze),
   .ref_sw    (ref_sw),
   .holdover  (holdover),
   .ofs_out   (ofs_out),
   .bias_out  (bias_out),
   .adj_out   (adj_out)
);

// File: tb/phase_buildout_ctrl_test.sv
module phase_buildout_ctrl_test;

   localparam int CLK_P = 10;
   localparam int WIN   = 64;
   localparam int NMEAS = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_err = '0;
   logic [15:0]        thr_large = 16'd1000;
   logic               cfg_en = 1'b1;
   logic               cfg_auto = 1'b1;
   logic               cfg_freeze = 1'b0;
   logic               lock_in = 1'b0;
   logic               ref_sw = 1'b0;
   logic signed [4:0]  fine_bias = '0;
   logic signed [16:0] adj_phase = '0;
   logic               holdover;
   logic signed [19:0] ofs_out;
   logic signed [4:0]  bias_out;
   logic signed [16:0] adj_out;

   int checks = 0;
   int failures = 0;
   int exp_ofs = 0;
   int exp_bias = 0;
   bit finished = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   phase_buildout_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_err   (smp_err),
      .thr_large (thr_large),
      .cfg_en    (cfg_en),
      .cfg_auto  (cfg_auto),
      .cfg_freeze(cfg_freeze),
      .lock_in   (lock_in),
      .ref_sw    (ref_sw),
      .fine_bias (fine_bias),
      .adj_phase (adj_phase),
      .holdover  (holdover),
      .ofs_out   (ofs_out),
      .bias_out  (bias_out),
      .adj_out   (adj_out)
   );

   function automatic int clampv(int v, int lim);
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input bit v, input int e);
      @(negedge clk);
      smp_valid = v;
      smp_err   = 16'(e);
      ref_sw    = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_sw();
      @(negedge clk);
      smp_valid = 1'b0;
      ref_sw    = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic set_en(input bit v);
      @(negedge clk);
      smp_valid = 1'b0;
      ref_sw    = 1'b0;
      cfg_en    = v;
      @(posedge clk);
      #1;
   endtask

   // four measure samples; the model adds floor(mean residual) plus clamped bias
   task automatic meas4(input int e0, input int e1, input int e2, input int e3);
      int errs[4];
      int s;
      errs[0] = e0; errs[1] = e1; errs[2] = e2; errs[3] = e3;
      s = 0;
      for (int i = 0; i < NMEAS; i++) begin
         s += errs[i] - exp_ofs;
         cyc(1'b1, errs[i]);
         if (i < NMEAS - 1)
            check("R4 holdover during measure", int'(holdover), 1);
      end
      exp_ofs = clampv(exp_ofs + (s >>> 2) + exp_bias, 524287);
      check("R4 holdover ends", int'(holdover), 0);
      check("R4 offset update", int'(ofs_out), exp_ofs);
   endtask

   task automatic t_reset();
      check("R1 reset ofs", int'(ofs_out), 0);
      check("R1 reset holdover", int'(holdover), 0);
      check("R1 reset adj", int'(adj_out), 0);
      check("R1 reset bias", int'(bias_out), 0);
   endtask

   task automatic t_transient();
      cyc(1'b1, 200);
      check("R2 window open no event", int'(holdover), 0);
      cyc(1'b1, 500);
      check("R2 below large thr", int'(holdover), 0);
      cyc(1'b1, 1500);
      check("R2 event fires", int'(holdover), 1);
      cyc(1'b1, 1500);
      cyc(1'b0, 9999);
      check("R12 invalid cycle keeps holdover", int'(holdover), 1);
      cyc(1'b1, 1500);
      cyc(1'b1, 1510);
      check("R12 third valid sample still holds", int'(holdover), 1);
      cyc(1'b1, 1490);
      exp_ofs = 1500;
      check("R4 holdover ends", int'(holdover), 0);
      check("R12 invalid sample not averaged", int'(ofs_out), exp_ofs);
   endtask

   task automatic t_switch_bias();
      fine_bias = 5'sd15;
      #1;
      check("R10 positive clamp", int'(bias_out), 14);
      fine_bias = 5'sd13;
      #1;
      check("R10 in range", int'(bias_out), 13);
      fine_bias = -5'sd16;
      #1;
      check("R10 negative clamp", int'(bias_out), -14);
      fine_bias = 5'sd15;
      exp_bias = 14;
      pulse_sw();
      check("R6 switch event", int'(holdover), 1);
      // residuals -3,-2,-2,-2 : floor(-9/4) = -3
      meas4(exp_ofs - 3, exp_ofs - 2, exp_ofs - 2, exp_ofs - 2);
      check("R4 floor with bias", int'(ofs_out), 1511);
      fine_bias = '0;
      exp_bias = 0;
   endtask

   task automatic t_window();
      int base;
      base = exp_ofs;
      cyc(1'b1, base + 156);
      cyc(1'b1, base + 2000);
      check("R2 strict small thr, first large only opens", int'(holdover), 0);
      for (int i = 0; i < WIN - 1; i++) cyc(1'b1, base);
      cyc(1'b1, base + 1001);
      check("R2 crossing at last window sample", int'(holdover), 1);
      meas4(base + 40, base + 40, base + 40, base + 40);
      base = exp_ofs;
      cyc(1'b1, base + 300);
      for (int i = 0; i < WIN; i++) cyc(1'b1, base);
      cyc(1'b1, base + 3000);
      check("R3 expired window no event", int'(holdover), 0);
      check("R3 offset unchanged", int'(ofs_out), exp_ofs);
      cyc(1'b1, base + 3000);
      check("R3 reopened window fires", int'(holdover), 1);
      meas4(base + 8, base + 8, base + 8, base + 8);
      base = exp_ofs;
      cyc(1'b1, base + 200);
      cyc(1'b1, base + 1000);
      check("R2 equal to large thr no event", int'(holdover), 0);
   endtask

   task automatic t_auto_off();
      int base;
      base = exp_ofs;
      cfg_auto = 1'b0;
      cyc(1'b1, base + 200);
      cyc(1'b1, base + 5000);
      cyc(1'b1, base + 5000);
      check("R5 no auto event", int'(holdover), 0);
      check("R5 offset kept", int'(ofs_out), exp_ofs);
      cfg_auto = 1'b1;
   endtask

   task automatic t_freeze();
      int base;
      base = exp_ofs;
      cfg_freeze = 1'b1;
      pulse_sw();
      check("R7 switch ignored", int'(holdover), 0);
      cyc(1'b1, base + 200);
      cyc(1'b1, base + 5000);
      cyc(1'b1, base + 5000);
      check("R7 transient ignored", int'(holdover), 0);
      check("R7 offset kept", int'(ofs_out), exp_ofs);
      cfg_freeze = 1'b0;
      cyc(1'b0, 0);
   endtask

   task automatic t_disable();
      adj_phase = 17'sd40000;
      #1;
      check("R11 adj zero while enabled", int'(adj_out), 0);
      lock_in = 1'b0;
      set_en(1'b0);
      exp_ofs = 0;
      check("R8 disable clears", int'(ofs_out), 0);
      check("R11 adj positive clamp", int'(adj_out), 33333);
      adj_phase = -17'sd5;
      #1;
      check("R11 adj in range", int'(adj_out), -5);
      adj_phase = -17'sd40000;
      #1;
      check("R11 adj negative clamp", int'(adj_out), -33333);
      set_en(1'b1);
      check("R9 enable unlocked no event", int'(holdover), 0);
      set_en(1'b0);
      lock_in = 1'b1;
      set_en(1'b1);
      check("R9 enable while locked fires", int'(holdover), 1);
      lock_in = 1'b0;
      meas4(100, 100, 100, 100);
   endtask

   task automatic t_collide();
      pulse_sw();
      check("R6 switch event", int'(holdover), 1);
      for (int i = 0; i < NMEAS - 1; i++) cyc(1'b1, 300);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_err   = 16'sd300;
      cfg_en    = 1'b0;
      @(posedge clk);
      #1;
      exp_ofs = 0;
      check("R8 clear wins over completion", int'(ofs_out), 0);
      check("R8 holdover dropped", int'(holdover), 0);
      set_en(1'b1);
      cyc(1'b1, 0);
      check("R8 no stale update", int'(ofs_out), 0);
      pulse_sw();
      cyc(1'b1, 70);
      cyc(1'b1, 70);
      set_en(1'b0);
      check("R8 abort mid measure", int'(holdover), 0);
      set_en(1'b1);
      cyc(1'b1, 0);
      check("R8 aborted measure leaves zero", int'(ofs_out), 0);
      pulse_sw();
      meas4(50, 50, 50, 50);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_transient();
      t_switch_bias();
      t_window();
      t_auto_off();
      t_freeze();
      t_disable();
      t_collide();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog all requirements actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule